// File: doc/BRIEF.md
# Input Handshake Device Responder

This block is the peripheral end of a tagged input transfer. The host places an address on the address lines and then raises its I/O-active tag. The device compares that address with its own configured address. On a match it raises select response. In the same clock it starts driving three things onto the input lines: a data byte, a parity bit over that byte, and a condition code. The byte and the code are taken from a local holding register at the moment of selection, and they stay frozen for the whole sequence.

The host may pulse strobe to take the data. Strobe ends the data phase: data, parity and condition code return to zero. Select response stays up until the host drops I/O active, and only then does the device release it. If I/O active falls while the data is still being driven and no strobe has come, the host did not accept the transfer. Local logic learns how each sequence ended from a one-clock accepted pulse or a one-clock rejected pulse. A device that is not selected holds all its input lines at zero.

All tags are sampled on the rising clock edge. Every output comes from a register, or from registered state through a gate.

Top module: `io_in_responder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output is zero.
- R2: Select response rises in the cycle after a clock edge that sees I/O active high with `addr_i == dev_addr_i` while the device is idle. It does not rise on a mismatch.
- R3: Once raised, select response stays high, strobe or no strobe. It falls in the cycle after the first edge that sees I/O active low.
- R4: Data and condition code show the values the holding register had at the selecting edge. They do not change for the rest of the data phase, even if the holding register changes.
- R5: The parity bit gives odd parity over the 9 bits made of the data byte and the parity bit. So it is 1 exactly when the data byte has an even number of ones, and 1 for the byte 0x00.
- R6: Data, parity and condition code are all zero whenever the device is not in its data phase. This includes the cycles after a strobe is taken while select response is still high.
- R7: Accepted pulses high for exactly one cycle after an edge that sees strobe high, I/O active high, and the device in its data phase. Strobe at any other time has no effect on any output.
- R8: Rejected pulses high for exactly one cycle after an edge that sees I/O active low while the device is in its data phase. Select response is low in that same cycle.
- R9: If I/O active is first seen high with a mismatching address, the device stays deselected until I/O active is seen low, even if the address later matches. After that it can be selected again.
- R10: If strobe and the fall of I/O active are seen at the same edge, the sequence counts as rejected and not as accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_active_i | input | 1 | Host I/O-active tag |
| addr_i | input | ADDR_W | Address lines from the host |
| dev_addr_i | input | ADDR_W | This device's configured address |
| strobe_i | input | 1 | Host strobe, data taken |
| hold_data_i | input | DATA_W | Local holding register, data byte |
| hold_cc_i | input | CC_W | Local holding register, condition code |
| sel_resp_o | output | 1 | Select response tag |
| data_o | output | DATA_W | Data bus in, zero when not driven |
| parity_o | output | 1 | Odd parity bit for data_o, zero when not driven |
| cc_o | output | CC_W | Condition code in, zero when not driven |
| accepted_o | output | 1 | One-cycle pulse: transfer taken by strobe |
| rejected_o | output | 1 | One-cycle pulse: I/O active fell without strobe |

## Verification
The bench builds the block with a 4-bit address, an 8-bit data byte and a 3-bit condition code. The narrow address lets short runs step through matching and mismatching values, including an address that changes to the device's own value in the middle of a sequence that started on a mismatch. The full byte width keeps the parity rule in play for both even and odd counts of ones, including the all-zero and all-one bytes. The 3-bit code shows that the condition-code lines are captured and released independently of the data byte.

// File: rtl/io_resp_pkg.sv
package io_resp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_HOLD  = 2'd2,
    ST_SKIP  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/io_resp_ctrl.sv
module io_resp_ctrl
  import io_resp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       io_active_i,
  input  logic       hit_i,
  input  logic       strobe_i,
  output seq_state_t state_o,
  output logic       capture_o,
  output logic       accept_o,
  output logic       reject_o
);
  seq_state_t state_q, state_d;
  logic       accept_q, reject_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (io_active_i) state_d = hit_i ? ST_DRIVE : ST_SKIP;
      end
      ST_DRIVE: begin
        // a falling tag wins over a simultaneous strobe
        if (!io_active_i)   state_d = ST_IDLE;
        else if (strobe_i)  state_d = ST_HOLD;
      end
      ST_HOLD, ST_SKIP: begin
        if (!io_active_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      accept_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      accept_q <= (state_q == ST_DRIVE) && io_active_i && strobe_i;
      reject_q <= (state_q == ST_DRIVE) && !io_active_i;
    end
  end

  assign state_o   = state_q;
  assign capture_o = (state_q == ST_IDLE) && io_active_i && hit_i;
  assign accept_o  = accept_q;
  assign reject_o  = reject_q;
endmodule

// File: rtl/io_resp_hold.sv
module io_resp_hold #(
  parameter int DATA_W = 8,
  parameter int CC_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CC_W-1:0]   cc_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CC_W-1:0]   cc_o,
  output logic              parity_o
);
  logic [DATA_W-1:0] data_q;
  logic [CC_W-1:0]   cc_q;
  logic              par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cc_q   <= '0;
      par_q  <= 1'b0;
    end else if (capture_i) begin
      data_q <= data_i;
      cc_q   <= cc_i;
      par_q  <= ~^data_i; // odd parity
    end
  end

  assign data_o   = data_q;
  assign cc_o     = cc_q;
  assign parity_o = par_q;
endmodule

// File: rtl/io_resp_gate.sv
module io_resp_gate #(
  parameter int W = 12
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q_o[i] = en_i & d_i[i];
  end
endmodule

// File: rtl/io_in_responder.sv
module io_in_responder
  import io_resp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CC_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_active_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic [CC_W-1:0]   hold_cc_i,
  output logic              sel_resp_o,
  output logic [DATA_W-1:0] data_o,
  output logic              parity_o,
  output logic [CC_W-1:0]   cc_o,
  output logic              accepted_o,
  output logic              rejected_o
);
  localparam int BUS_W = DATA_W + CC_W + 1;

  seq_state_t        state;
  logic              hit, capture;
  logic [DATA_W-1:0] data_q;
  logic [CC_W-1:0]   cc_q;
  logic              par_q;
  logic [BUS_W-1:0]  bus_raw, bus_out;

  assign hit = (addr_i == dev_addr_i);

  io_resp_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .io_active_i (io_active_i),
    .hit_i       (hit),
    .strobe_i    (strobe_i),
    .state_o     (state),
    .capture_o   (capture),
    .accept_o    (accepted_o),
    .reject_o    (rejected_o)
  );

  io_resp_hold #(.DATA_W(DATA_W), .CC_W(CC_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .data_i    (hold_data_i),
    .cc_i      (hold_cc_i),
    .data_o    (data_q),
    .cc_o      (cc_q),
    .parity_o  (par_q)
  );

  assign bus_raw = {par_q, cc_q, data_q};

  io_resp_gate #(.W(BUS_W)) u_gate (
    .en_i (state == ST_DRIVE),
    .d_i  (bus_raw),
    .q_o  (bus_out)
  );

  assign data_o     = bus_out[DATA_W-1:0];
  assign cc_o       = bus_out[DATA_W +: CC_W];
  assign parity_o   = bus_out[BUS_W-1];
  assign sel_resp_o = (state == ST_DRIVE) || (state == ST_HOLD);
endmodule

// File: rtl/io_resp_chk.sv
module io_resp_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CC_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_active_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] dev_addr_i,
  input logic              strobe_i,
  input logic              sel_resp_o,
  input logic [DATA_W-1:0] data_o,
  input logic              parity_o,
  input logic [CC_W-1:0]   cc_o,
  input logic              accepted_o,
  input logic              rejected_o
);
  assert_sel_rise_on_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_resp_o) |-> $past(io_active_i && (addr_i == dev_addr_i)));

  assert_sel_fall_on_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_resp_o) |-> !$past(io_active_i));

  assert_data_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != '0 && $past(data_o) != '0) |-> $stable(data_o));

  assert_odd_parity_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != '0) |-> (^{data_o, parity_o}));

  assert_lines_need_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != '0 || cc_o != '0 || parity_o) |-> sel_resp_o);

  assert_accept_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accepted_o |=> !accepted_o);

  assert_accept_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accepted_o |-> (sel_resp_o && data_o == '0 && cc_o == '0 && !parity_o));

  assert_reject_desel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rejected_o |-> !sel_resp_o);

  assert_outcome_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({accepted_o, rejected_o}));
endmodule

bind io_in_responder io_resp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CC_W(CC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .io_active_i (io_active_i),
  .addr_i      (addr_i),
  .dev_addr_i  (dev_addr_i),
  .strobe_i    (strobe_i),
  .sel_resp_o  (sel_resp_o),
  .data_o      (data_o),
  .parity_o    (parity_o),
  .cc_o        (cc_o),
  .accepted_o  (accepted_o),
  .rejected_o  (rejected_o)
);

// File: tb/sim_io_in_responder.sv
module sim_io_in_responder;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          io_act = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] dev = 4'h9;
  logic          stb = 1'b0;
  logic [DW-1:0] hdata = '0;
  logic [CW-1:0] hcc = '0;
  logic          sel, par, acc, rej;
  logic [DW-1:0] data;
  logic [CW-1:0] cc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R2";

  always #2 clk = ~clk;

  io_in_responder #(.ADDR_W(AW), .DATA_W(DW), .CC_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .io_active_i(io_act), .addr_i(addr),
    .dev_addr_i(dev), .strobe_i(stb), .hold_data_i(hdata), .hold_cc_i(hcc),
    .sel_resp_o(sel), .data_o(data), .parity_o(par), .cc_o(cc),
    .accepted_o(acc), .rejected_o(rej)
  );

  // reference model: 0 idle, 1 data phase, 2 strobed, 3 not addressed
  int m_st = 0;
  int m_d = 0, m_c = 0, m_p = 0, m_acc = 0, m_rej = 0;

  function automatic int odd_bit(input int v);
    int n = 0;
    for (int i = 0; i < DW; i++) n += (v >> i) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_d <= 0; m_c <= 0; m_p <= 0; m_acc <= 0; m_rej <= 0;
    end else begin
      m_acc <= (m_st == 1 && io_act && stb) ? 1 : 0;
      m_rej <= (m_st == 1 && !io_act) ? 1 : 0;
      case (m_st)
        0: if (io_act) begin
             if (addr == dev) begin
               m_st <= 1; m_d <= int'(hdata); m_c <= int'(hcc); m_p <= odd_bit(int'(hdata));
             end else m_st <= 3;
           end
        1: if (!io_act) m_st <= 0; else if (stb) m_st <= 2;
        default: if (!io_act) m_st <= 0;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk({tag, "/R3"}, "sel_resp", int'(sel), (m_st == 1 || m_st == 2) ? 1 : 0);
      chk({tag, "/R4"}, "data", int'(data), (m_st == 1) ? m_d : 0);
      chk({tag, "/R4"}, "cc", int'(cc), (m_st == 1) ? m_c : 0);
      chk({tag, "/R5"}, "parity", int'(par), (m_st == 1) ? m_p : 0);
      chk({tag, "/R7"}, "accepted", int'(acc), m_acc);
      chk({tag, "/R8"}, "rejected", int'(rej), m_rej);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one host sequence; strobe at cycle s (s == len: together with the drop, s < 0: none)
  task automatic run_seq(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [CW-1:0] c,
                         input int s, input int len, input bit churn);
    addr = a; hdata = d; hcc = c;
    io_act = 1'b1;
    for (int i = 0; i < len; i++) begin
      stb = (i == s);
      step(1);
      stb = 1'b0;
      if (churn) begin hdata = ~hdata; hcc = ~hcc; end
    end
    io_act = 1'b0;
    stb = (s == len);
    step(1);
    stb = 1'b0;
    step(2);
  endtask

  initial begin
    fork
      begin
        while (cycles < 100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    tag = "R1";
    step(3);
    chk("R1", "reset outputs", int'({sel, data, par, cc, acc, rej}), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1", "post reset outputs", int'({sel, data, par, cc, acc, rej}), 0);

    tag = "R7";
    run_seq(4'h9, 8'hA5, 3'd5, 2, 5, 1'b0);
    tag = "R5";
    run_seq(4'h9, 8'h00, 3'd0, 1, 3, 1'b0);
    run_seq(4'h9, 8'hFF, 3'd7, 1, 3, 1'b0);
    run_seq(4'h9, 8'h01, 3'd2, 1, 3, 1'b0);
    tag = "R4";
    run_seq(4'h9, 8'h3C, 3'd6, 4, 6, 1'b1);
    tag = "R8";
    run_seq(4'h9, 8'h5A, 3'd1, -1, 4, 1'b1);
    tag = "R10";
    run_seq(4'h9, 8'h81, 3'd3, 3, 3, 1'b0);
    tag = "R2";
    for (int k = 0; k < 16; k++) run_seq(AW'(k), DW'(k * 37), CW'(k), 1, 2, 1'b0);

    // R9: sequence starts on a mismatch, address then moves onto the device
    tag = "R9";
    addr = 4'h3; hdata = 8'h77; io_act = 1'b1;
    step(1);
    addr = 4'h9;
    step(3);
    chk("R9", "late match ignored sel", int'(sel), 0);
    io_act = 1'b0;
    step(2);
    run_seq(4'h9, 8'h42, 3'd4, 1, 3, 1'b0);

    // R6: after strobe the lines are released while select stays up
    tag = "R6";
    addr = 4'h9; hdata = 8'hC3; hcc = 3'd7; io_act = 1'b1;
    step(1);
    stb = 1'b1;
    step(1);
    stb = 1'b0;
    chk("R6", "sel after strobe", int'(sel), 1);
    chk("R6", "lines after strobe", int'({data, par, cc}), 0);
    // R7: second strobe in the hold phase has no effect
    stb = 1'b1;
    step(1);
    stb = 1'b0;
    step(1);
    chk("R7", "late strobe accepted", int'(acc), 0);
    chk("R3", "sel held", int'(sel), 1);
    io_act = 1'b0;
    step(1);
    chk("R3", "sel dropped", int'(sel), 0);
    chk("R8", "no reject after accept", int'(rej), 0);

    // R7: strobe with nobody selected
    tag = "R7";
    stb = 1'b1;
    step(2);
    stb = 1'b0;
    chk("R7", "idle strobe outputs", int'({sel, data, par, cc, acc, rej}), 0);
    step(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule